// File: doc/BRIEF.md
# Multi-Mode 16-Bit Timer and Event Counter

This block is a 16-bit up-counter with two compare channels, a small register bus and one output line. A three-bit mode field in an 8-bit control register decides what the counter does. It can be halted at zero, or it can produce a pulse-width waveform. It can run freely and wrap. It can also restart from zero on an external event or on a match with compare channel 0. In the free-running and restart modes, the low bit of the mode field decides which events flip the output line: compare matches only, or compare matches plus the external event.

Counting advances only on cycles where the `tick` input is high, so a prescaler outside the block sets the counting rate. The external event arrives as a one-cycle pulse that has already been edge-detected and filtered. Each compare channel drives its own one-cycle interrupt line. A sticky overflow flag in the control register records every pass of the counter from FFFFH to 0000H. Software clears the flag through the bus.

Top module: `ev_timer16`

## Requirements
- R1: After reset, the control register, both compare registers, the counter, `timerOut`, `irqMatch0` and `irqMatch1` are all 0.
- R2: Bus address 0 is the control register: bits 3:1 hold the mode and bit 0 holds the overflow flag, and bits 15:4 read 0. Address 1 is compare 0, address 2 is compare 1 and address 3 reads the counter. Bus writes to address 3 are ignored.
- R3: In mode 000, the counter becomes 0 on the next clock whatever `tick` is. `timerOut` holds its value, no interrupt pulses, and no overflow is recorded.
- R4: In modes 001 to 111, each clock with `tick` high adds one to the counter, unless a clear applies. A clock with `tick` low and no clearing event leaves the counter unchanged. A new mode takes effect from the clock after the write.
- R5: In modes 010 and 011, the counter is never cleared by a match: it passes from FFFFH to 0000H and sets the overflow flag on that clock.
- R6: In modes 100 and 101, an `extEdge` pulse clears the counter on the next clock, with or without `tick`, and takes priority over the increment.
- R7: In modes 110 and 111, a tick while the counter equals compare 0 loads 0 into the counter.
- R8: In modes 010 to 111, a tick while the counter equals compare 0 or compare 1 inverts `timerOut` once on the next clock.
- R9: In the odd modes 011, 101 and 111, an `extEdge` pulse also inverts `timerOut`; coinciding sources invert it only once. In the even modes 010, 100 and 110, `extEdge` has no effect on `timerOut`.
- R10: In any mode other than 000, a tick while the counter equals compare 0 (or compare 1) makes `irqMatch0` (or `irqMatch1`) high for the following cycle.
- R11: The overflow flag is sticky. Overflow is also recorded when a mode-110/111 clear happens with compare 0 at FFFFH. A control write with bit 0 = 0 clears the flag, and a write with bit 0 = 1 leaves it alone. A hardware set in the same clock as a clearing write wins.
- R12: In mode 001, the counter runs freely, and `timerOut` is high while the counter is below compare 0 and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable from the prescaler |
| extEdge | input | 1 | One-cycle pulse marking a valid external edge |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 2 | Register address, used for both reads and writes |
| busWrData | input | 16 | Write data |
| busRdData | output | 16 | Read data for `busAddr`, combinational |
| timerOut | output | 1 | Timer output line |
| irqMatch0 | output | 1 | Compare 0 match interrupt pulse |
| irqMatch1 | output | 1 | Compare 1 match interrupt pulse |

## Verification
The bench first checks the two ways the counter can pass through FFFFH: a free-running wrap, and a compare-0 clear with compare 0 at FFFFH. A design that only watched the increment path would leave the flag clear in the second case. On that same clock a clearing write lands, so a design that favoured software would lose the overflow. The bench sends an `extEdge` on a tick clock in the restart-on-edge mode, where a design that let the increment win would read 3 instead of 0. It also sends `extEdge` with no tick, and an edge in an even mode, where the flag-driven toggle must not move. It checks that a mode write only acts from the next clock: a halt written mid-count must leave the count in place for one more clock, and an early decode would zero it at once.

// File: rtl/ev_timer_pkg.sv
package ev_timer_pkg;

  localparam int NUM_CMP    = 2;
  localparam int REG_ADDR_W = 2;
  localparam int MODE_W     = 3;

  localparam logic [REG_ADDR_W-1:0] ADDR_CTRL  = 2'd0;
  localparam logic [REG_ADDR_W-1:0] ADDR_CMP0  = 2'd1;
  localparam logic [REG_ADDR_W-1:0] ADDR_CMP1  = 2'd2;
  localparam logic [REG_ADDR_W-1:0] ADDR_COUNT = 2'd3;

  typedef enum logic [MODE_W-1:0] {
    MODE_STOP     = 3'b000,
    MODE_PWM      = 3'b001,
    MODE_FREE     = 3'b010,
    MODE_FREE_E   = 3'b011,
    MODE_EDGECLR  = 3'b100,
    MODE_EDGECLR_E= 3'b101,
    MODE_MATCHCLR = 3'b110,
    MODE_MATCHCLR_E=3'b111
  } mode_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic               run;
    logic               pwm;
    logic               clrOnEdge;
    logic               clrOnMatch;
    logic               toggleOnMatch;
    logic               toggleOnEdge;
    logic [NUM_CMP-1:0] cmpWr;
  } strobes_t;

endpackage

// File: rtl/ev_timer_ctrl.sv
module ev_timer_ctrl
  import ev_timer_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busWrEn,
  input  logic [REG_ADDR_W-1:0] busAddr,
  input  logic [3:0]            ctrlWrData,
  input  logic                  ovfEvent,
  output mode_e                 mode,
  output logic                  ovfFlag,
  output strobes_t              strobes
);

  logic  wrCtrl;
  mode_e modeQ;
  logic  ovfQ;

  assign wrCtrl = busWrEn && (busAddr == ADDR_CTRL);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= MODE_STOP;
      ovfQ  <= 1'b0;
    end else begin
      if (wrCtrl) begin
        modeQ <= mode_e'(ctrlWrData[3:1]);
      end
      // Hardware set beats a software clear in the same clock
      if (ovfEvent) begin
        ovfQ <= 1'b1;
      end else if (wrCtrl && !ctrlWrData[0]) begin
        ovfQ <= 1'b0;
      end
    end
  end

  always_comb begin
    strobes.run           = (modeQ != MODE_STOP);
    strobes.pwm           = (modeQ == MODE_PWM);
    strobes.clrOnEdge     = (modeQ == MODE_EDGECLR) || (modeQ == MODE_EDGECLR_E);
    strobes.clrOnMatch    = (modeQ == MODE_MATCHCLR) || (modeQ == MODE_MATCHCLR_E);
    strobes.toggleOnMatch = modeQ[2] || modeQ[1];
    strobes.toggleOnEdge  = (modeQ[2] || modeQ[1]) && modeQ[0];
  end

  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmpWr
    assign strobes.cmpWr[i] = busWrEn &&
                              (busAddr == REG_ADDR_W'(int'(ADDR_CMP0) + i));
  end

  assign mode    = modeQ;
  assign ovfFlag = ovfQ;

endmodule

// File: rtl/ev_timer_dp.sv
module ev_timer_dp
  import ev_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          tick,
  input  logic                          extEdge,
  input  strobes_t                      strobes,
  input  logic [CNT_W-1:0]              wrData,
  output logic [CNT_W-1:0]              count,
  output logic [NUM_CMP-1:0][CNT_W-1:0] cmpOut,
  output logic [NUM_CMP-1:0]            irq,
  output logic                          timerOut,
  output logic                          ovfEvent
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0]   countQ;
  logic [CNT_W-1:0]   countNext;
  logic [CNT_W-1:0]   cmpQ [NUM_CMP];
  logic               irqQ [NUM_CMP];
  logic [NUM_CMP-1:0] hit;
  logic               toggleQ;
  logic               edgeClr;
  logic               matchClr;
  logic               toggleEv;

  // Compare channels
  for (genvar i = 0; i < NUM_CMP; i++) begin : g_cmp
    always_ff @(posedge clk) begin
      if (!rstN) begin
        cmpQ[i] <= '0;
      end else if (strobes.cmpWr[i]) begin
        cmpQ[i] <= wrData;
      end
    end

    assign hit[i] = strobes.run && tick && (countQ == cmpQ[i]);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        irqQ[i] <= 1'b0;
      end else begin
        irqQ[i] <= hit[i];
      end
    end

    assign cmpOut[i] = cmpQ[i];
    assign irq[i]    = irqQ[i];
  end

  assign edgeClr  = strobes.clrOnEdge && extEdge;
  assign matchClr = strobes.clrOnMatch && hit[0];

  always_comb begin
    if (!strobes.run) begin
      countNext = '0;
    end else if (edgeClr) begin
      countNext = '0;
    end else if (tick) begin
      countNext = matchClr ? '0 : countQ + 1'b1;
    end else begin
      countNext = countQ;
    end
  end

  assign ovfEvent = strobes.run && tick && !edgeClr && (countQ == CNT_MAX);

  assign toggleEv = (strobes.toggleOnMatch && (|hit)) ||
                    (strobes.toggleOnEdge && extEdge);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ  <= '0;
      toggleQ <= 1'b0;
    end else begin
      countQ  <= countNext;
      toggleQ <= toggleQ ^ toggleEv;
    end
  end

  assign count    = countQ;
  assign timerOut = strobes.pwm ? (countQ < cmpQ[0]) : toggleQ;

endmodule

// File: rtl/ev_timer16.sv
module ev_timer16
  import ev_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  tick,
  input  logic                  extEdge,
  input  logic                  busWrEn,
  input  logic [REG_ADDR_W-1:0] busAddr,
  input  logic [CNT_W-1:0]      busWrData,
  output logic [CNT_W-1:0]      busRdData,
  output logic                  timerOut,
  output logic                  irqMatch0,
  output logic                  irqMatch1
);

  strobes_t                      strobes;
  mode_e                         modeVal;
  logic                          ovfFlag;
  logic                          ovfEvent;
  logic [CNT_W-1:0]              countVal;
  logic [NUM_CMP-1:0][CNT_W-1:0] cmpVal;
  logic [NUM_CMP-1:0]            irqVec;

  ev_timer_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .busWrEn    (busWrEn),
    .busAddr    (busAddr),
    .ctrlWrData (busWrData[3:0]),
    .ovfEvent   (ovfEvent),
    .mode       (modeVal),
    .ovfFlag    (ovfFlag),
    .strobes    (strobes)
  );

  ev_timer_dp #(.CNT_W(CNT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .tick     (tick),
    .extEdge  (extEdge),
    .strobes  (strobes),
    .wrData   (busWrData),
    .count    (countVal),
    .cmpOut   (cmpVal),
    .irq      (irqVec),
    .timerOut (timerOut),
    .ovfEvent (ovfEvent)
  );

  always_comb begin
    busRdData = '0;
    case (busAddr)
      ADDR_CTRL: busRdData[3:0] = {modeVal, ovfFlag};
      ADDR_CMP0: busRdData      = cmpVal[0];
      ADDR_CMP1: busRdData      = cmpVal[1];
      default:   busRdData      = countVal;
    endcase
  end

  assign irqMatch0 = irqVec[0];
  assign irqMatch1 = irqVec[1];

endmodule

// File: rtl/ev_timer16_chk.sv
module ev_timer16_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             tick,
  input logic             extEdge,
  input logic             busWrEn,
  input logic [1:0]       busAddr,
  input logic [CNT_W-1:0] busWrData,
  input logic             timerOut,
  input logic             irqMatch0,
  input logic             irqMatch1,
  input logic [2:0]       mode,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] cmp0,
  input logic             ovfFlag
);

  logic ctrlWr;
  assign ctrlWr = busWrEn && (busAddr == 2'd0);

  a_r3_stop_zero: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 3'b000) |=> (count == '0));

  a_r3_stop_no_irq: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 3'b000) |=> (!irqMatch0 && !irqMatch1));

  a_r3_stop_out_hold: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 3'b000 && !ctrlWr) |=> $stable(timerOut));

  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (mode != 3'b000 && !tick && !extEdge) |=> $stable(count));

  a_r5_wrap: assert property (@(posedge clk) disable iff (!rstN)
    ((mode == 3'b010 || mode == 3'b011) && tick && count == {CNT_W{1'b1}})
      |=> (count == '0 && ovfFlag));

  a_r7_match_clear: assert property (@(posedge clk) disable iff (!rstN)
    (mode[2:1] == 2'b11 && tick && count == cmp0) |=> (count == '0));

  a_r10_irq0: assert property (@(posedge clk) disable iff (!rstN)
    (mode != 3'b000 && tick && count == cmp0) |=> irqMatch0);

  a_r11_ovf_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !(ctrlWr && !busWrData[0])) |=> ovfFlag);

endmodule

bind ev_timer16 ev_timer16_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .tick      (tick),
  .extEdge   (extEdge),
  .busWrEn   (busWrEn),
  .busAddr   (busAddr),
  .busWrData (busWrData),
  .timerOut  (timerOut),
  .irqMatch0 (irqMatch0),
  .irqMatch1 (irqMatch1),
  .mode      (modeVal),
  .count     (countVal),
  .cmp0      (cmpVal[0]),
  .ovfFlag   (ovfFlag)
);

// File: tb/tb_ev_timer16.sv
`timescale 1ns/1ps
module tb_ev_timer16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0;
  logic        extEdge = 1'b0;
  logic        busWrEn = 1'b0;
  logic [1:0]  busAddr = 2'd0;
  logic [15:0] busWrData = 16'h0000;
  logic [15:0] busRdData;
  logic        timerOut;
  logic        irqMatch0;
  logic        irqMatch1;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  ev_timer16 dut (
    .clk(clk), .rstN(rstN), .tick(tick), .extEdge(extEdge),
    .busWrEn(busWrEn), .busAddr(busAddr), .busWrData(busWrData),
    .busRdData(busRdData), .timerOut(timerOut),
    .irqMatch0(irqMatch0), .irqMatch1(irqMatch1)
  );

  typedef struct packed {
    logic        wr;
    logic [1:0]  addr;
    logic [15:0] data;
    logic        tk;
    logic        ex;
    logic [15:0] cnt;
    logic        out;
    logic        i0;
    logic        i1;
  } vec_t;

  // compare 0 = 3, compare 1 = 1; expected values hold after each clock
  localparam int NVEC = 22;
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 2'd1, 16'h0003, 1'b0, 1'b0, 16'd0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 2'd2, 16'h0001, 1'b0, 1'b0, 16'd0, 1'b0, 1'b0, 1'b0},
    '{1'b1, 2'd0, 16'h000C, 1'b0, 1'b0, 16'd0, 1'b0, 1'b0, 1'b0}, // mode 110
    '{1'b0, 2'd0, 16'h0000, 1'b1, 1'b0, 16'd1, 1'b0, 1'b0, 1'b0}, // R4
    '{1'b0, 2'd0, 16'h0000, 1'b1, 1'b0, 16'd2, 1'b1, 1'b0, 1'b1}, // R8 R10 cmp1
    '{1'b0, 2'd0, 16'h0000, 1'b0, 1'b0, 16'd2, 1'b1, 1'b0, 1'b0}, // R4 hold
    '{1'b0, 2'd0, 16'h0000, 1'b1, 1'b0, 16'd3, 1'b1, 1'b0, 1'b0},
    '{1'b0, 2'd0, 16'h0000, 1'b1, 1'b0, 16'd0, 1'b0, 1'b1, 1'b0}, // R7 R8 R10
    '{1'b0, 2'd0, 16'h0000, 1'b0, 1'b1, 16'd0, 1'b0, 1'b0, 1'b0}, // R9 even ignores edge
    '{1'b1, 2'd0, 16'h000B, 1'b0, 1'b0, 16'd0, 1'b0, 1'b0, 1'b0}, // mode 101
    '{1'b0, 2'd0, 16'h0000, 1'b1, 1'b0, 16'd1, 1'b0, 1'b0, 1'b0},
    '{1'b0, 2'd0, 16'h0000, 1'b0, 1'b1, 16'd0, 1'b1, 1'b0, 1'b0}, // R6 no tick, R9 toggle
    '{1'b0, 2'd0, 16'h0000, 1'b1, 1'b0, 16'd1, 1'b1, 1'b0, 1'b0},
    '{1'b0, 2'd0, 16'h0000, 1'b1, 1'b0, 16'd2, 1'b0, 1'b0, 1'b1}, // R8
    '{1'b0, 2'd0, 16'h0000, 1'b1, 1'b1, 16'd0, 1'b1, 1'b0, 1'b0}, // R6 priority
    '{1'b1, 2'd0, 16'h0006, 1'b1, 1'b0, 16'd1, 1'b1, 1'b0, 1'b0}, // mode 011 next clock
    '{1'b0, 2'd0, 16'h0000, 1'b1, 1'b0, 16'd2, 1'b0, 1'b0, 1'b1},
    '{1'b0, 2'd0, 16'h0000, 1'b1, 1'b0, 16'd3, 1'b0, 1'b0, 1'b0},
    '{1'b0, 2'd0, 16'h0000, 1'b1, 1'b0, 16'd4, 1'b1, 1'b1, 1'b0}, // R5 no clear on match
    '{1'b0, 2'd0, 16'h0000, 1'b1, 1'b1, 16'd5, 1'b0, 1'b0, 1'b0}, // R9 odd free-run
    '{1'b1, 2'd0, 16'h0000, 1'b0, 1'b0, 16'd5, 1'b0, 1'b0, 1'b0}, // R4 stop waits a clock
    '{1'b0, 2'd0, 16'h0000, 1'b0, 1'b0, 16'd0, 1'b0, 1'b0, 1'b0}  // R3
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    busAddr = a;
    #1;
    v = busRdData;
  endtask

  // Called at a falling edge; returns at the next falling edge
  task automatic step(input logic wr, input logic [1:0] a, input logic [15:0] d,
                      input logic t, input logic e);
    busWrEn = wr; busAddr = a; busWrData = d; tick = t; extEdge = e;
    @(posedge clk);
    #1;
    busWrEn = 1'b0; tick = 1'b0; extEdge = 1'b0;
    @(negedge clk);
  endtask

  task automatic runTicks(input int n);
    tick = 1'b1;
    repeat (n) @(posedge clk);
    #1;
    tick = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic        outBefore;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(2'd0, v); chk("R1 ctrl", v, 16'h0000);
    rd(2'd1, v); chk("R1 cmp0", v, 16'h0000);
    rd(2'd2, v); chk("R1 cmp1", v, 16'h0000);
    rd(2'd3, v); chk("R1 count", v, 16'h0000);
    chk("R1 out", 16'(timerOut), 16'h0);
    chk("R1 irqs", 16'({irqMatch0, irqMatch1}), 16'h0);

    // Vector table: modes 110, 101, 011, then stop
    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i].wr, VEC[i].addr, VEC[i].data, VEC[i].tk, VEC[i].ex);
      rd(2'd3, v);
      chk($sformatf("R4 R6 R7 R8 R9 R10 row %0d count", i), v, VEC[i].cnt);
      chk($sformatf("R8 R9 row %0d out", i), 16'(timerOut), 16'(VEC[i].out));
      chk($sformatf("R10 row %0d irq0", i), 16'(irqMatch0), 16'(VEC[i].i0));
      chk($sformatf("R10 row %0d irq1", i), 16'(irqMatch1), 16'(VEC[i].i1));
    end

    // R5 free-running wrap
    step(1'b1, 2'd0, 16'h0004, 1'b0, 1'b0);
    runTicks(65535);
    rd(2'd3, v); chk("R5 count at top", v, 16'hFFFF);
    rd(2'd0, v); chk("R5 flag before wrap", v, 16'h0004);
    step(1'b0, 2'd0, 16'h0000, 1'b1, 1'b0);
    rd(2'd3, v); chk("R5 count wrapped", v, 16'h0000);
    rd(2'd0, v); chk("R5 flag set", v, 16'h0005);
    step(1'b1, 2'd0, 16'h0005, 1'b0, 1'b0);
    rd(2'd0, v); chk("R11 write 1 keeps flag", v, 16'h0005);
    step(1'b1, 2'd0, 16'h0004, 1'b0, 1'b0);
    rd(2'd0, v); chk("R11 write 0 clears flag", v, 16'h0004);

    // R11 match-clear at FFFFH with coinciding clear write
    step(1'b1, 2'd1, 16'hFFFF, 1'b0, 1'b0);
    step(1'b1, 2'd0, 16'h000C, 1'b0, 1'b0);
    runTicks(65535);
    rd(2'd3, v); chk("R7 count at top", v, 16'hFFFF);
    step(1'b1, 2'd0, 16'h000C, 1'b1, 1'b0);
    rd(2'd3, v); chk("R7 cleared at FFFF", v, 16'h0000);
    rd(2'd0, v); chk("R11 hw set beats clear", v, 16'h000D);
    chk("R10 irq0 at FFFF", 16'(irqMatch0), 16'h1);
    step(1'b1, 2'd0, 16'h000C, 1'b0, 1'b0);
    rd(2'd0, v); chk("R11 cleared", v, 16'h000C);
    step(1'b1, 2'd0, 16'h000D, 1'b0, 1'b0);
    rd(2'd0, v); chk("R11 write 1 does not set", v, 16'h000C);

    // R3 stop mode
    runTicks(3);
    outBefore = timerOut;
    step(1'b1, 2'd0, 16'h0000, 1'b0, 1'b0);
    rd(2'd3, v); chk("R4 mode change next clock", v, 16'h0003);
    step(1'b0, 2'd0, 16'h0000, 1'b0, 1'b0);
    rd(2'd3, v); chk("R3 forced zero", v, 16'h0000);
    step(1'b1, 2'd1, 16'h0000, 1'b0, 1'b0);
    step(1'b1, 2'd2, 16'h0000, 1'b0, 1'b0);
    step(1'b0, 2'd0, 16'h0000, 1'b1, 1'b1);
    rd(2'd3, v); chk("R3 count stays zero", v, 16'h0000);
    chk("R3 no irqs", 16'({irqMatch0, irqMatch1}), 16'h0);
    chk("R3 out held", 16'(timerOut), 16'(outBefore));
    rd(2'd0, v); chk("R3 no overflow", v, 16'h0000);

    // R12 PWM with compare 0 = 3
    step(1'b1, 2'd1, 16'h0003, 1'b0, 1'b0);
    step(1'b1, 2'd0, 16'h0002, 1'b0, 1'b0);
    chk("R12 pwm at 0", 16'(timerOut), 16'h1);
    step(1'b0, 2'd0, 16'h0000, 1'b1, 1'b0);
    chk("R12 pwm at 1", 16'(timerOut), 16'h1);
    step(1'b0, 2'd0, 16'h0000, 1'b1, 1'b0);
    chk("R12 pwm at 2", 16'(timerOut), 16'h1);
    step(1'b0, 2'd0, 16'h0000, 1'b1, 1'b0);
    chk("R12 pwm at 3", 16'(timerOut), 16'h0);
    step(1'b0, 2'd0, 16'h0000, 1'b1, 1'b0);
    chk("R12 pwm at 4", 16'(timerOut), 16'h0);
    rd(2'd3, v); chk("R12 free count", v, 16'h0004);

    // R2 register layout
    step(1'b1, 2'd0, 16'hFFFF, 1'b0, 1'b0);
    rd(2'd0, v); chk("R2 ctrl upper bits zero", v, 16'h000E);
    rd(2'd3, v); chk("R2 count before write", v, 16'h0004);
    step(1'b1, 2'd3, 16'h1234, 1'b0, 1'b0);
    rd(2'd3, v); chk("R2 count write ignored", v, 16'h0004);
    rd(2'd1, v); chk("R2 cmp0 readback", v, 16'h0003);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule